// File: doc/BRIEF.md
# Gain Step Indicator Generator

This block watches a stream of signed 14-bit converter samples, one per clock, and gives an external gain controller two hints. The decrement-gain flag warns quickly that the signal is getting too large. The increment-gain flag reports that the signal has stayed small long enough that the gain can safely be raised. The three compare flags behind these hints (coarse upper, fine upper and fine lower) are also brought out.

Each sample becomes an unsigned 13-bit magnitude. A coarse compare looks at the top three magnitude bits and answers one cycle after the sample arrives. The fine compares use the full magnitude from the pipeline register and answer one cycle later. A threshold T corresponds to 20·log10(T/8192) dBFS. The fine-lower compare drives a dwell timer. The increment flag is raised only after a run of consecutive small samples as long as the programmed dwell count. Any sample at or above the lower threshold restarts that run.

Every flag follows the instantaneous level and not an envelope. Once a flag rises, it stays high for at least two cycles.

Top module: `gain_step_ind`

## Requirements
- R1: The magnitude is the absolute value of the 14-bit two's-complement sample. The code -8192 saturates to 8191, and +8191 and -8191 also give 8191.
- R2: `coarse_up_o` is driven by the compare magnitude[12:10] > `coarse_thr_i` on the sample presented one clock earlier.
- R3: `fine_up_o` is driven by the compare magnitude > `fine_upper_i` on the sample presented two clocks earlier.
- R4: `fine_low_o` is driven by the compare magnitude < `fine_lower_i` on the sample presented two clocks earlier.
- R5: `dec_gain_o` is high exactly when `coarse_up_o` or `fine_up_o` is high.
- R6: `inc_gain_o` is driven high in the same cycle as `fine_low_o` for the D-th consecutive sample below the lower threshold, where D is `dwell_i`. The valid range of D is 1 to 65535, and the run count saturates rather than wraps.
- R7: A sample whose magnitude is not below `fine_lower_i` restarts the run. `inc_gain_o` then needs D new consecutive low samples before it rises again, and after its minimum width it drops with `fine_low_o`.
- R8: A dwell value of 0 behaves exactly like 1.
- R9: Each output flag rises in the cycle its compare first holds, and then stays high for at least two cycles. After that it is high only while its compare holds.
- R10: While `rst` is high at a clock edge, every output flag and the dwell run are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | 14 | Signed two's-complement sample |
| coarse_thr_i | input | 3 | Coarse upper threshold on magnitude bits [12:10] |
| fine_upper_i | input | 13 | Fine upper magnitude threshold |
| fine_lower_i | input | 13 | Fine lower magnitude threshold |
| dwell_i | input | 16 | Dwell length in samples (0 is taken as 1) |
| coarse_up_o | output | 1 | Coarse upper compare flag |
| fine_up_o | output | 1 | Fine upper compare flag |
| fine_low_o | output | 1 | Fine lower compare flag |
| inc_gain_o | output | 1 | Increment-gain indicator |
| dec_gain_o | output | 1 | Decrement-gain indicator |

## Verification
The bench goes after the most negative sample code. A magnitude that wraps would hide a full-scale negative peak from both upper compares.

It drives one-sample spikes and dips. A design without the two-cycle hold would show one-cycle flag pulses. A design whose stretch is too long would keep the flags high after the level has returned.

The dwell tests interrupt a run one sample before it completes, then count a fresh run. A timer that does not restart, or that is off by one, raises `inc_gain_o` a cycle early or late. Setting the dwell value to 0 catches a timer that never fires or that wraps.

// File: rtl/gsi_pkg.sv
package gsi_pkg;
  // Raw compare events, one bit per output flag that has its own stretcher.
  typedef struct packed {
    logic coarse_up;
    logic fine_up;
    logic fine_low;
    logic inc;
  } gsi_raw_t;

  localparam int unsigned GSI_NUM_FLAGS = $bits(gsi_raw_t);
endpackage

// File: rtl/gsi_mag_stage.sv
module gsi_mag_stage #(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned COARSE_W = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic [COARSE_W-1:0]        coarse_thr_i,
  output logic [SAMPLE_W-2:0]        mag_q_o,
  output logic                       coarse_hit_o
);
  localparam int unsigned MAG_W = SAMPLE_W - 1;

  // Absolute value with saturation of the most negative code.
  function automatic logic [MAG_W-1:0] abs_sat(input logic signed [SAMPLE_W-1:0] s);
    logic [SAMPLE_W-1:0] neg;
    neg = ~s + 1'b1;
    if (!s[SAMPLE_W-1])        return s[MAG_W-1:0];
    else if (neg[SAMPLE_W-1])  return {MAG_W{1'b1}};
    else                       return neg[MAG_W-1:0];
  endfunction

  logic [MAG_W-1:0] mag_now;

  always_comb begin
    mag_now      = abs_sat(sample_i);
    coarse_hit_o = mag_now[MAG_W-1 -: COARSE_W] > coarse_thr_i;
  end

  always_ff @(posedge clk) begin
    if (rst) mag_q_o <= '0;
    else     mag_q_o <= mag_now;
  end
endmodule

// File: rtl/gsi_dwell_timer.sv
module gsi_dwell_timer #(
  parameter int unsigned DWELL_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               below_i,
  input  logic [DWELL_W-1:0] dwell_i,
  output logic               due_o
);
  logic [DWELL_W-1:0] run_q;
  logic [DWELL_W:0]   run_incl;
  logic [DWELL_W:0]   target;

  function automatic logic [DWELL_W:0] eff_dwell(input logic [DWELL_W-1:0] d);
    return (d == '0) ? {{DWELL_W{1'b0}}, 1'b1} : {1'b0, d};
  endfunction

  always_comb begin
    run_incl = {1'b0, run_q} + 1'b1;
    target   = eff_dwell(dwell_i);
    due_o    = below_i && (run_incl >= target);
  end

  always_ff @(posedge clk) begin
    if (rst)                     run_q <= '0;
    else if (!below_i)           run_q <= '0;
    else if (run_q != '1)        run_q <= run_q + 1'b1;
  end
endmodule

// File: rtl/gsi_min_hold.sv
module gsi_min_hold (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic flag_o
);
  logic fresh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o  <= 1'b0;
      fresh_q <= 1'b0;
    end else begin
      flag_o  <= raw_i | (flag_o & fresh_q);
      fresh_q <= raw_i & ~flag_o;
    end
  end
endmodule

// File: rtl/gain_step_ind.sv
module gain_step_ind #(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned COARSE_W = 3,
  parameter int unsigned DWELL_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic [COARSE_W-1:0]        coarse_thr_i,
  input  logic [SAMPLE_W-2:0]        fine_upper_i,
  input  logic [SAMPLE_W-2:0]        fine_lower_i,
  input  logic [DWELL_W-1:0]         dwell_i,
  output logic                       coarse_up_o,
  output logic                       fine_up_o,
  output logic                       fine_low_o,
  output logic                       inc_gain_o,
  output logic                       dec_gain_o
);
  import gsi_pkg::*;
  localparam int unsigned MAG_W = SAMPLE_W - 1;

  logic [MAG_W-1:0] mag_q;
  logic             coarse_raw;
  logic             fine_up_raw;
  logic             fine_low_raw;
  logic             inc_raw;
  gsi_raw_t         raw_evt;
  logic [GSI_NUM_FLAGS-1:0] raw_vec;
  logic [GSI_NUM_FLAGS-1:0] flag_vec;

  gsi_mag_stage #(.SAMPLE_W(SAMPLE_W), .COARSE_W(COARSE_W)) u_mag (
    .clk(clk), .rst(rst), .sample_i(sample_i), .coarse_thr_i(coarse_thr_i),
    .mag_q_o(mag_q), .coarse_hit_o(coarse_raw)
  );

  always_comb begin
    fine_up_raw  = mag_q > fine_upper_i;
    fine_low_raw = mag_q < fine_lower_i;
  end

  gsi_dwell_timer #(.DWELL_W(DWELL_W)) u_dwell (
    .clk(clk), .rst(rst), .below_i(fine_low_raw), .dwell_i(dwell_i), .due_o(inc_raw)
  );

  always_comb begin
    raw_evt.coarse_up = coarse_raw;
    raw_evt.fine_up   = fine_up_raw;
    raw_evt.fine_low  = fine_low_raw;
    raw_evt.inc       = inc_raw;
    raw_vec           = raw_evt;
  end

  for (genvar g = 0; g < GSI_NUM_FLAGS; g++) begin : g_hold
    gsi_min_hold u_hold (.clk(clk), .rst(rst), .raw_i(raw_vec[g]), .flag_o(flag_vec[g]));
  end

  always_comb begin
    coarse_up_o = flag_vec[3];
    fine_up_o   = flag_vec[2];
    fine_low_o  = flag_vec[1];
    inc_gain_o  = flag_vec[0];
    dec_gain_o  = coarse_up_o | fine_up_o;
  end
endmodule

// File: rtl/gsi_checker.sv
module gsi_checker (
  input logic clk,
  input logic rst,
  input logic coarse_raw,
  input logic fine_low_raw,
  input logic inc_raw,
  input logic coarse_up_o,
  input logic fine_up_o,
  input logic fine_low_o,
  input logic inc_gain_o,
  input logic dec_gain_o
);
  // R9: a raw compare always lifts its flag on the next edge
  p_raw_lifts_coarse_r9: assert property (@(posedge clk) disable iff (rst)
    coarse_raw |=> coarse_up_o);

  // R9: a fresh rise is held for a second cycle
  p_min_width_inc_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(inc_gain_o) |=> inc_gain_o);

  p_min_width_coarse_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(coarse_up_o) |=> coarse_up_o);

  // R9: a low flag with no raw event stays low
  p_no_spurious_low_r9: assert property (@(posedge clk) disable iff (rst)
    (!fine_low_raw && !fine_low_o) |=> !fine_low_o);

  // R5: decrement covers both upper flags
  p_dec_cover_r5: assert property (@(posedge clk) disable iff (rst)
    (coarse_up_o || fine_up_o) |-> dec_gain_o);

  // R6: increment can only rise together with the lower compare flag
  p_inc_needs_low_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(inc_gain_o) |-> fine_low_o);

  // R7: a timer firing requires the sample to be below the lower threshold
  p_due_only_below_r7: assert property (@(posedge clk) disable iff (rst)
    inc_raw |-> fine_low_raw);

  // R10: reset clears the flags
  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> (!coarse_up_o && !fine_up_o && !fine_low_o && !inc_gain_o));
endmodule

bind gain_step_ind gsi_checker u_chk (
  .clk(clk), .rst(rst),
  .coarse_raw(coarse_raw), .fine_low_raw(fine_low_raw), .inc_raw(inc_raw),
  .coarse_up_o(coarse_up_o), .fine_up_o(fine_up_o), .fine_low_o(fine_low_o),
  .inc_gain_o(inc_gain_o), .dec_gain_o(dec_gain_o)
);

// File: tb/tb_gain_step_ind.sv
module tb_gain_step_ind;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [13:0] sample_i = '0;
  logic [2:0]  coarse_thr_i = 3'd7;
  logic [12:0] fine_upper_i = 13'h1FFF;
  logic [12:0] fine_lower_i = 13'd0;
  logic [15:0] dwell_i = 16'd1;
  logic coarse_up_o, fine_up_o, fine_low_o, inc_gain_o, dec_gain_o;

  int vectors = 0;
  int miscompares = 0;

  // reference state: magnitudes presented one and two clocks before the check
  int m1, m2, run;
  bit pc1, pc2, pu1, pu2, pl1, pl2, pi1, pi2;

  always #4 clk = ~clk;

  gain_step_ind dut (
    .clk(clk), .rst(rst), .sample_i(sample_i), .coarse_thr_i(coarse_thr_i),
    .fine_upper_i(fine_upper_i), .fine_lower_i(fine_lower_i), .dwell_i(dwell_i),
    .coarse_up_o(coarse_up_o), .fine_up_o(fine_up_o), .fine_low_o(fine_low_o),
    .inc_gain_o(inc_gain_o), .dec_gain_o(dec_gain_o)
  );

  function automatic int ref_mag(input int s);
    int m;
    m = (s < 0) ? -s : s;
    return (m > 8191) ? 8191 : m;
  endfunction

  task automatic cmp(input bit act, input bit exp, input string what);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0b expected %0b at %0t", what, act, exp, $time);
    end
  endtask

  // R10: hold reset, check flags cleared, release with a zero sample
  task automatic do_reset(input int cthr, input int fup, input int flo, input int dw);
    @(negedge clk);
    rst = 1'b1; sample_i = '0;
    coarse_thr_i = 3'(cthr); fine_upper_i = 13'(fup);
    fine_lower_i = 13'(flo); dwell_i = 16'(dw);
    repeat (2) @(negedge clk);
    vectors++;
    cmp(coarse_up_o | fine_up_o | fine_low_o | inc_gain_o | dec_gain_o, 1'b0, "R10 flags in reset");
    rst = 1'b0;
    m1 = 0; m2 = 0; run = 0;
    {pc1, pc2, pu1, pu2, pl1, pl2, pi1, pi2} = '0;
  endtask

  // one clock: check outputs from earlier samples, then present a new sample
  task automatic step(input int s, input string tag);
    bit rc, ru, rl, ri, ec, eu, el, ei;
    int d;
    @(negedge clk);
    d  = (dwell_i == 0) ? 1 : int'(dwell_i);
    rc = (m1 / 1024) > int'(coarse_thr_i);
    ru = m2 > int'(fine_upper_i);
    rl = m2 < int'(fine_lower_i);
    run = rl ? run + 1 : 0;
    ri = rl && (run >= d);
    // a flag that rose in the last cycle is kept one more cycle
    ec = rc | (pc1 & !pc2);
    eu = ru | (pu1 & !pu2);
    el = rl | (pl1 & !pl2);
    ei = ri | (pi1 & !pi2);
    vectors++;
    cmp(coarse_up_o, ec, {tag, " R2 coarse"});
    cmp(fine_up_o,   eu, {tag, " R3 fine upper"});
    cmp(fine_low_o,  el, {tag, " R4 fine lower"});
    cmp(dec_gain_o,  ec | eu, {tag, " R5 decrement"});
    cmp(inc_gain_o,  ei, {tag, " R6 increment"});
    pc2 = pc1; pc1 = ec; pu2 = pu1; pu1 = eu;
    pl2 = pl1; pl1 = el; pi2 = pi1; pi1 = ei;
    sample_i = 14'(s);
    m2 = m1; m1 = ref_mag(s);
  endtask

  task automatic t_magnitude;  // R1
    do_reset(6, 8190, 0, 1);
    step(-8192, "R1"); step(0, "R1"); step(0, "R1"); step(0, "R1");
    step(8191, "R1");  step(0, "R1"); step(0, "R1"); step(0, "R1");
    step(-8191, "R1"); step(-1, "R1"); step(1, "R1"); step(0, "R1"); step(0, "R1");
  endtask

  task automatic t_coarse;  // R2
    do_reset(3, 8191, 0, 1);
    for (int k = 0; k < 12; k++) step((k % 2 == 0) ? 4096 : -4095, "R2");
    step(4095, "R2"); step(-4096, "R2"); step(0, "R2"); step(0, "R2"); step(0, "R2");
  endtask

  task automatic t_fine;  // R3 R4 R5
    do_reset(7, 2000, 500, 100);
    step(2001, "R3"); step(2001, "R3"); step(2000, "R3"); step(-2001, "R3");
    step(-2001, "R3"); step(-2001, "R3");
    step(499, "R4"); step(-499, "R4"); step(500, "R4"); step(-500, "R4");
    step(100, "R4"); step(100, "R4"); step(100, "R4"); step(1000, "R5");
    step(1000, "R5"); step(1000, "R5"); step(1000, "R5");
  endtask

  task automatic t_dwell;  // R6
    do_reset(7, 8191, 300, 5);
    step(1000, "R6"); step(1000, "R6"); step(1000, "R6");
    for (int k = 0; k < 9; k++) step(10, "R6");
    step(1000, "R6"); step(1000, "R6"); step(1000, "R6"); step(1000, "R6");
    dwell_i = 16'd40;
    for (int k = 0; k < 48; k++) step(-20, "R6");
    step(1000, "R6"); step(1000, "R6"); step(1000, "R6");
  endtask

  task automatic t_restart;  // R7
    do_reset(7, 8191, 300, 6);
    step(900, "R7"); step(900, "R7");
    for (int k = 0; k < 5; k++) step(5, "R7");
    step(300, "R7");
    for (int k = 0; k < 5; k++) step(5, "R7");
    step(-300, "R7");
    for (int k = 0; k < 9; k++) step(5, "R7");
    step(900, "R7"); step(5, "R7"); step(900, "R7"); step(900, "R7"); step(900, "R7");
  endtask

  task automatic t_dwell_zero;  // R8
    do_reset(7, 8191, 300, 0);
    step(900, "R8"); step(900, "R8"); step(900, "R8");
    step(5, "R8"); step(900, "R8"); step(900, "R8"); step(900, "R8");
    step(5, "R8"); step(5, "R8"); step(5, "R8"); step(900, "R8"); step(900, "R8"); step(900, "R8");
  endtask

  task automatic t_min_width;  // R9
    do_reset(2, 3000, 200, 1);
    step(1000, "R9"); step(1000, "R9");
    step(5000, "R9"); step(1000, "R9"); step(1000, "R9"); step(1000, "R9");
    step(-5000, "R9"); step(-5000, "R9"); step(1000, "R9"); step(1000, "R9");
    step(5000, "R9"); step(1000, "R9"); step(5000, "R9"); step(1000, "R9"); step(1000, "R9");
    step(10, "R9"); step(1000, "R9"); step(1000, "R9"); step(1000, "R9"); step(1000, "R9");
  endtask

  task automatic t_reset_mid;  // R10
    do_reset(1, 100, 8000, 1);
    for (int k = 0; k < 4; k++) step(6000, "R10");
    do_reset(1, 100, 8000, 1);
    step(0, "R10"); step(0, "R10"); step(0, "R10");
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_magnitude();
    t_coarse();
    t_fine();
    t_dwell();
    t_restart();
    t_dwell_zero();
    t_min_width();
    t_reset_mid();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule